// File: doc/BRIEF.md
# Reorder-buffer head commit unit

This unit sits beside a reorder buffer and decides, every cycle, which of the oldest entries leave it. The buffer presents a window of its oldest `COMMIT_WIDTH` entries in age order, slot 0 being the oldest. Each entry carries a valid bit, a completed bit, a non-speculative bit, a sequence number and a thread number. The unit returns a retirement mask over that window in the same cycle, so the buffer can advance its head at the next clock edge.

Instructions marked non-speculative may not execute until they are the oldest in the machine. When such an entry reaches slot 0 and has not yet completed, the unit sends its sequence number back to the issue stages once. It then waits for the entry to complete before retiring it. Every cycle spent waiting on such an entry increments a stall counter. The unit also tracks, per thread, how many buffer entries are occupied. It reports the free count and pulses an update flag only when some count moved. It releases trap handling only once no store is outstanding, and it keeps a histogram of the number of entries retired per cycle.

Top module: `rob_head_commit`

## Requirements
- R1: Slot i is in `retire_mask` only if every slot older than i is also in it, so the mask is a run of ones starting at bit 0. `retire_cnt` equals the number of ones, from 0 to `COMMIT_WIDTH`.
- R2: A slot that is not valid or not completed is not retired. No younger slot retires in the same cycle, even a completed one.
- R3: A non-speculative entry retires only from slot 0. In any other slot it is not retired and blocks every younger slot, whatever its completed bit.
- R4: When slot 0 holds a valid, non-speculative, incomplete entry that has not been released, `rel_valid` is 1 in the next cycle with `rel_seq` equal to that entry's sequence number. Only slot 0 can be released, so there is at most one release per cycle.
- R5: An entry already released is not released again while it waits at slot 0. `rel_valid` stays 0 until a different entry qualifies.
- R6: `stall_cnt` increases by exactly 1 after each cycle in which slot 0 holds a valid, non-speculative, incomplete entry. Otherwise it holds its value.
- R7: Thread t's free count is `free_cnt[t*OCC_W +: OCC_W]` and equals `PART_DEPTH` minus that thread's occupancy. Occupancy changes one cycle after an allocation (+1) or after retired slots tagged with t (-1 each).
- R8: `free_upd` is 1 in the cycle after some thread's occupancy changed by a nonzero net amount, and 0 otherwise. An allocation and a retirement for the same thread in the same cycle cancel and give no update.
- R9: `trap_go` is 1 in the cycle after a cycle with `trap_req`=1 and `stores_pending`=0, and is 0 after any cycle with a pending store.
- R10: Bin k of `hist_flat`, at bits `[k*CNT_W +: CNT_W]` for k from 0 to `COMMIT_WIDTH`, counts the cycles since reset in which `retire_cnt` was k.
- R11: After reset, every free count is `PART_DEPTH`, and every counter, histogram bin, `rel_valid`, `free_upd` and `trap_go` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_valid | input | COMMIT_WIDTH | Slot holds an entry; bit 0 is the oldest |
| head_done | input | COMMIT_WIDTH | Slot entry has completed |
| head_nonspec | input | COMMIT_WIDTH | Slot entry must not execute before being oldest |
| head_seq | input | COMMIT_WIDTH*SEQ_W | Sequence numbers, slot i at `[i*SEQ_W +: SEQ_W]` |
| head_tid | input | COMMIT_WIDTH*TID_W | Thread numbers, slot i at `[i*TID_W +: TID_W]` |
| alloc_valid | input | 1 | One entry is written into the buffer this cycle |
| alloc_tid | input | TID_W | Thread of the allocated entry |
| trap_req | input | 1 | A trap or interrupt is waiting to be taken |
| stores_pending | input | 1 | At least one store has not been written back |
| retire_mask | output | COMMIT_WIDTH | Slots retired this cycle |
| retire_cnt | output | CW | Number of slots retired this cycle |
| rel_valid | output | 1 | A non-speculative entry is released to issue |
| rel_seq | output | SEQ_W | Sequence number of the released entry |
| stall_cnt | output | CNT_W | Cycles blocked behind a waiting non-speculative head |
| free_upd | output | 1 | Free counts changed; earlier stages should take them |
| free_cnt | output | NUM_THREADS*OCC_W | Per-thread free entries |
| trap_go | output | 1 | Trap handling may proceed |
| hist_flat | output | (COMMIT_WIDTH+1)*CNT_W | Histogram of retirements per cycle |

## Verification
The hardest state to reach from the ports is a non-speculative entry that sits behind older work with its completed bit already set. Only there can a faulty unit retire it out of slot 0 or let younger entries slip past it. The bench builds this deliberately: it queues ordinary entries, allocates one non-speculative entry behind them and forces every window slot complete. It then checks that retirement stops at that entry and takes it one cycle later from slot 0. Long random runs, in which the bench completes a non-speculative entry only after it has seen that entry released, cover repeated waits at the head, back-to-back releases and partitions filled to the limit.

// File: rtl/rob_commit_pkg.sv
package rob_commit_pkg;

    // Verdict for one slot of the head window, before the age chain is applied.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_HELD  = 2'd2,
        SLOT_READY = 2'd3
    } slot_state_t;

    // A non-speculative entry is only eligible from the oldest slot.
    function automatic slot_state_t classify_slot(
        input logic valid,
        input logic done,
        input logic nonspec,
        input logic is_oldest
    );
        if (!valid)                 return SLOT_EMPTY;
        if (nonspec && !is_oldest)  return SLOT_HELD;
        if (!done)                  return SLOT_WAIT;
        return SLOT_READY;
    endfunction

    // Oldest entry is non-speculative and still waiting to execute.
    function automatic logic head_blocked(
        input logic valid,
        input logic done,
        input logic nonspec
    );
        return valid && nonspec && !done;
    endfunction

endpackage

// File: rtl/rob_commit_select.sv
module rob_commit_select
    import rob_commit_pkg::*;
#(
    parameter int W  = 4,
    parameter int CW = 3
) (
    input  logic [W-1:0]  slot_valid,
    input  logic [W-1:0]  slot_done,
    input  logic [W-1:0]  slot_nonspec,
    output logic [W-1:0]  retire_mask,
    output logic [CW-1:0] retire_cnt
);

    slot_state_t verdict [W];
    logic [W:0]  older_ok;

    assign older_ok[0] = 1'b1;

    generate
        for (genvar i = 0; i < W; i++) begin : g_slot
            localparam logic IS_OLDEST = (i == 0) ? 1'b1 : 1'b0;
            assign verdict[i]     = classify_slot(slot_valid[i], slot_done[i],
                                                  slot_nonspec[i], IS_OLDEST);
            assign retire_mask[i] = older_ok[i] && (verdict[i] == SLOT_READY);
            assign older_ok[i+1]  = retire_mask[i];
        end
    endgenerate

    always_comb begin
        retire_cnt = '0;
        for (int i = 0; i < W; i++) begin
            retire_cnt = retire_cnt + CW'(retire_mask[i]);
        end
    end

endmodule

// File: rtl/rob_nonspec_gate.sv
module rob_nonspec_gate
    import rob_commit_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_valid,
    input  logic             head_done,
    input  logic             head_nonspec,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic             head_retire,
    output logic             rel_valid,
    output logic [SEQ_W-1:0] rel_seq,
    output logic [CNT_W-1:0] stall_cnt
);

    logic             held_q;
    logic [SEQ_W-1:0] held_seq_q;
    logic             waiting;
    logic             same_as_held;
    logic             fire;

    assign waiting      = head_blocked(head_valid, head_done, head_nonspec);
    assign same_as_held = held_q && (held_seq_q == head_seq);
    assign fire         = waiting && !same_as_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_valid  <= 1'b0;
            rel_seq    <= '0;
            held_q     <= 1'b0;
            held_seq_q <= '0;
            stall_cnt  <= '0;
        end else begin
            rel_valid <= fire;
            if (fire) begin
                rel_seq    <= head_seq;
                held_q     <= 1'b1;
                held_seq_q <= head_seq;
            end else if (head_retire && head_nonspec && same_as_held) begin
                held_q <= 1'b0;
            end
            if (waiting) begin
                stall_cnt <= stall_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rob_free_tracker.sv
module rob_free_tracker #(
    parameter int W          = 4,
    parameter int NT         = 2,
    parameter int TID_W      = 1,
    parameter int PART_DEPTH = 16,
    parameter int OCC_W      = 5,
    parameter int CW         = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W*TID_W-1:0]  slot_tid,
    input  logic [W-1:0]        retire_mask,
    input  logic                alloc_valid,
    input  logic [TID_W-1:0]    alloc_tid,
    output logic                free_upd,
    output logic [NT*OCC_W-1:0] free_cnt
);

    logic [NT-1:0] moved;

    generate
        for (genvar t = 0; t < NT; t++) begin : g_thr
            logic [OCC_W-1:0] occ_q;
            logic [OCC_W-1:0] occ_nxt;
            logic [CW-1:0]    dec;
            logic             inc;

            always_comb begin
                dec = '0;
                for (int i = 0; i < W; i++) begin
                    if (retire_mask[i] && (slot_tid[i*TID_W +: TID_W] == TID_W'(t))) begin
                        dec = dec + 1'b1;
                    end
                end
            end

            assign inc      = alloc_valid && (alloc_tid == TID_W'(t));
            assign occ_nxt  = occ_q + OCC_W'(inc) - OCC_W'(dec);
            assign moved[t] = (OCC_W'(inc) != OCC_W'(dec));

            always_ff @(posedge clk) begin
                if (rst) occ_q <= '0;
                else     occ_q <= occ_nxt;
            end

            assign free_cnt[t*OCC_W +: OCC_W] = OCC_W'(PART_DEPTH) - occ_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) free_upd <= 1'b0;
        else     free_upd <= |moved;
    end

endmodule

// File: rtl/rob_retire_hist.sv
module rob_retire_hist #(
    parameter int W     = 4,
    parameter int CW    = 3,
    parameter int CNT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CW-1:0]          retire_cnt,
    output logic [(W+1)*CNT_W-1:0] hist_flat
);

    generate
        for (genvar k = 0; k <= W; k++) begin : g_bin
            logic [CNT_W-1:0] bin_q;
            always_ff @(posedge clk) begin
                if (rst)                         bin_q <= '0;
                else if (retire_cnt == CW'(k))   bin_q <= bin_q + 1'b1;
            end
            assign hist_flat[k*CNT_W +: CNT_W] = bin_q;
        end
    endgenerate

endmodule

// File: rtl/rob_head_commit.sv
module rob_head_commit #(
    parameter int COMMIT_WIDTH = 4,
    parameter int NUM_THREADS  = 2,
    parameter int PART_DEPTH   = 16,
    parameter int SEQ_W        = 16,
    parameter int CNT_W        = 32,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int OCC_W = $clog2(PART_DEPTH + 1),
    localparam int CW    = $clog2(COMMIT_WIDTH + 1)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [COMMIT_WIDTH-1:0]             head_valid,
    input  logic [COMMIT_WIDTH-1:0]             head_done,
    input  logic [COMMIT_WIDTH-1:0]             head_nonspec,
    input  logic [COMMIT_WIDTH*SEQ_W-1:0]       head_seq,
    input  logic [COMMIT_WIDTH*TID_W-1:0]       head_tid,
    input  logic                                alloc_valid,
    input  logic [TID_W-1:0]                    alloc_tid,
    input  logic                                trap_req,
    input  logic                                stores_pending,
    output logic [COMMIT_WIDTH-1:0]             retire_mask,
    output logic [CW-1:0]                       retire_cnt,
    output logic                                rel_valid,
    output logic [SEQ_W-1:0]                    rel_seq,
    output logic [CNT_W-1:0]                    stall_cnt,
    output logic                                free_upd,
    output logic [NUM_THREADS*OCC_W-1:0]        free_cnt,
    output logic                                trap_go,
    output logic [(COMMIT_WIDTH+1)*CNT_W-1:0]   hist_flat
);

    rob_commit_select #(
        .W (COMMIT_WIDTH),
        .CW(CW)
    ) u_select (
        .slot_valid  (head_valid),
        .slot_done   (head_done),
        .slot_nonspec(head_nonspec),
        .retire_mask (retire_mask),
        .retire_cnt  (retire_cnt)
    );

    rob_nonspec_gate #(
        .SEQ_W(SEQ_W),
        .CNT_W(CNT_W)
    ) u_gate (
        .clk         (clk),
        .rst         (rst),
        .head_valid  (head_valid[0]),
        .head_done   (head_done[0]),
        .head_nonspec(head_nonspec[0]),
        .head_seq    (head_seq[SEQ_W-1:0]),
        .head_retire (retire_mask[0]),
        .rel_valid   (rel_valid),
        .rel_seq     (rel_seq),
        .stall_cnt   (stall_cnt)
    );

    rob_free_tracker #(
        .W         (COMMIT_WIDTH),
        .NT        (NUM_THREADS),
        .TID_W     (TID_W),
        .PART_DEPTH(PART_DEPTH),
        .OCC_W     (OCC_W),
        .CW        (CW)
    ) u_free (
        .clk        (clk),
        .rst        (rst),
        .slot_tid   (head_tid),
        .retire_mask(retire_mask),
        .alloc_valid(alloc_valid),
        .alloc_tid  (alloc_tid),
        .free_upd   (free_upd),
        .free_cnt   (free_cnt)
    );

    rob_retire_hist #(
        .W    (COMMIT_WIDTH),
        .CW   (CW),
        .CNT_W(CNT_W)
    ) u_hist (
        .clk       (clk),
        .rst       (rst),
        .retire_cnt(retire_cnt),
        .hist_flat (hist_flat)
    );

    // Trap handling waits for every outstanding store to drain.
    always_ff @(posedge clk) begin
        if (rst) trap_go <= 1'b0;
        else     trap_go <= trap_req && !stores_pending;
    end

endmodule

// File: rtl/rob_head_commit_chk.sv
module rob_head_commit_chk #(
    parameter int COMMIT_WIDTH = 4,
    parameter int NUM_THREADS  = 2,
    parameter int PART_DEPTH   = 16,
    parameter int SEQ_W        = 16,
    parameter int CNT_W        = 32,
    localparam int OCC_W = $clog2(PART_DEPTH + 1),
    localparam int CW    = $clog2(COMMIT_WIDTH + 1)
) (
    input logic                          clk,
    input logic                          rst,
    input logic [COMMIT_WIDTH-1:0]       head_valid,
    input logic [COMMIT_WIDTH-1:0]       head_done,
    input logic [COMMIT_WIDTH-1:0]       head_nonspec,
    input logic [COMMIT_WIDTH*SEQ_W-1:0] head_seq,
    input logic                          trap_req,
    input logic                          stores_pending,
    input logic [COMMIT_WIDTH-1:0]       retire_mask,
    input logic [CW-1:0]                 retire_cnt,
    input logic                          rel_valid,
    input logic [SEQ_W-1:0]              rel_seq,
    input logic [CNT_W-1:0]              stall_cnt,
    input logic                          free_upd,
    input logic [NUM_THREADS*OCC_W-1:0]  free_cnt,
    input logic                          trap_go
);

    // R1: mask is a run of ones from the oldest slot
    a_r1_contiguous: assert property (@(posedge clk) disable iff (rst)
        (COMMIT_WIDTH'(retire_mask + 1'b1) & retire_mask) == '0);

    // R1: count agrees with the mask
    a_r1_count: assert property (@(posedge clk) disable iff (rst)
        32'(retire_cnt) == $countones(retire_mask));

    // R2: only valid, completed slots leave
    a_r2_incomplete_stays: assert property (@(posedge clk) disable iff (rst)
        (retire_mask & ~(head_valid & head_done)) == '0);

    // R3: non-speculative entries only leave from slot 0
    generate
        if (COMMIT_WIDTH > 1) begin : g_r3
            a_r3_nonspec_oldest_only: assert property (@(posedge clk) disable iff (rst)
                (retire_mask[COMMIT_WIDTH-1:1] & head_nonspec[COMMIT_WIDTH-1:1]) == '0);
        end
    endgenerate

    // R4: a release follows a waiting non-speculative head and carries its number
    a_r4_release_source: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> ($past(head_valid[0] && head_nonspec[0] && !head_done[0])
                       && (rel_seq == $past(head_seq[SEQ_W-1:0]))));

    // R5: no entry is released in two consecutive cycles
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && $past(rel_valid)) |-> (rel_seq != $past(rel_seq)));

    // R6: stall counter steps by one behind a waiting head
    a_r6_stall_step: assert property (@(posedge clk) disable iff (rst)
        (head_valid[0] && head_nonspec[0] && !head_done[0])
        |=> (stall_cnt == $past(stall_cnt) + 1'b1));

    // R7: a free count never exceeds the partition size
    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_r7
            a_r7_free_bound: assert property (@(posedge clk) disable iff (rst)
                free_cnt[t*OCC_W +: OCC_W] <= OCC_W'(PART_DEPTH));
        end
    endgenerate

    // R8: the update flag accompanies a change and only a change
    a_r8_upd_on_change: assert property (@(posedge clk) disable iff (rst)
        free_upd |-> (free_cnt != $past(free_cnt)));

    a_r8_quiet_when_stable: assert property (@(posedge clk) disable iff (rst)
        !free_upd |-> $stable(free_cnt));

    // R9: trap handling only after stores have drained
    a_r9_trap_after_drain: assert property (@(posedge clk) disable iff (rst)
        trap_go |-> $past(trap_req && !stores_pending));

endmodule

bind rob_head_commit rob_head_commit_chk #(
    .COMMIT_WIDTH(COMMIT_WIDTH),
    .NUM_THREADS (NUM_THREADS),
    .PART_DEPTH  (PART_DEPTH),
    .SEQ_W       (SEQ_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .head_valid    (head_valid),
    .head_done     (head_done),
    .head_nonspec  (head_nonspec),
    .head_seq      (head_seq),
    .trap_req      (trap_req),
    .stores_pending(stores_pending),
    .retire_mask   (retire_mask),
    .retire_cnt    (retire_cnt),
    .rel_valid     (rel_valid),
    .rel_seq       (rel_seq),
    .stall_cnt     (stall_cnt),
    .free_upd      (free_upd),
    .free_cnt      (free_cnt),
    .trap_go       (trap_go)
);

// File: tb/sim_rob_head_commit.sv
`timescale 1ns/1ps
module sim_rob_head_commit;

    localparam int W   = 4;
    localparam int NT  = 2;
    localparam int PD  = 16;
    localparam int SW  = 16;
    localparam int CNW = 32;
    localparam int TW  = 1;
    localparam int OW  = 5;
    localparam int CW  = 3;
    localparam int QD  = NT * PD;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [W-1:0]       head_valid = '0;
    logic [W-1:0]       head_done = '0;
    logic [W-1:0]       head_nonspec = '0;
    logic [W*SW-1:0]    head_seq = '0;
    logic [W*TW-1:0]    head_tid = '0;
    logic               alloc_valid = 1'b0;
    logic [TW-1:0]      alloc_tid = '0;
    logic               trap_req = 1'b0;
    logic               stores_pending = 1'b0;
    logic [W-1:0]       retire_mask;
    logic [CW-1:0]      retire_cnt;
    logic               rel_valid;
    logic [SW-1:0]      rel_seq;
    logic [CNW-1:0]     stall_cnt;
    logic               free_upd;
    logic [NT*OW-1:0]   free_cnt;
    logic               trap_go;
    logic [(W+1)*CNW-1:0] hist_flat;

    rob_head_commit #(
        .COMMIT_WIDTH(W), .NUM_THREADS(NT), .PART_DEPTH(PD), .SEQ_W(SW), .CNT_W(CNW)
    ) u0 (
        .clk(clk), .rst(rst),
        .head_valid(head_valid), .head_done(head_done), .head_nonspec(head_nonspec),
        .head_seq(head_seq), .head_tid(head_tid),
        .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
        .trap_req(trap_req), .stores_pending(stores_pending),
        .retire_mask(retire_mask), .retire_cnt(retire_cnt),
        .rel_valid(rel_valid), .rel_seq(rel_seq), .stall_cnt(stall_cnt),
        .free_upd(free_upd), .free_cnt(free_cnt), .trap_go(trap_go),
        .hist_flat(hist_flat)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reorder buffer model: circular queue
    int q_seq [QD];
    int q_tid [QD];
    bit q_ns  [QD];
    bit q_done[QD];
    bit q_rel [QD];
    int qh = 0, qn = 0;
    int occ [NT];
    int next_seq = 1;

    // Expected registered outputs
    bit  e_rel_v = 0;
    int  e_rel_seq = 0;
    longint e_stall = 0;
    bit  e_free_upd = 0;
    int  e_free [NT];
    bit  e_trap = 0;
    longint e_hist [W+1];

    // Stimulus knobs (percent)
    int p_alloc = 0, p_ns = 0, p_done = 0;

    task automatic chk(string tag, longint got, longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic int win_idx(int i);
        return (qh + i) % QD;
    endfunction

    task automatic check_regs();
        chk("R4 rel_valid", rel_valid, e_rel_v);
        if (e_rel_v) chk("R4 rel_seq", rel_seq, e_rel_seq);
        chk("R6 stall_cnt", stall_cnt, e_stall);
        for (int t = 0; t < NT; t++) chk("R7 free_cnt", free_cnt[t*OW +: OW], e_free[t]);
        chk("R8 free_upd", free_upd, e_free_upd);
        chk("R9 trap_go", trap_go, e_trap);
        for (int k = 0; k <= W; k++) chk("R10 hist bin", hist_flat[k*CNW +: CNW], e_hist[k]);
    endtask

    task automatic complete_random();
        for (int i = 0; i < qn; i++) begin
            int idx = win_idx(i);
            if (!q_done[idx] && (!q_ns[idx] || q_rel[idx]) && ($urandom % 100 < p_done))
                q_done[idx] = 1;
        end
    endtask

    task automatic force_done(int i);
        q_done[win_idx(i)] = 1;
    endtask

    task automatic step();
        int  m, cnt, a_tid, net;
        bit  a_v, going, upd, ns_alloc;
        check_regs();
        complete_random();
        // drive the head window from the model
        for (int i = 0; i < W; i++) begin
            int idx = win_idx(i);
            if (i < qn) begin
                head_valid[i]   = 1'b1;
                head_done[i]    = q_done[idx];
                head_nonspec[i] = q_ns[idx];
                head_seq[i*SW +: SW] = SW'(q_seq[idx]);
                head_tid[i*TW +: TW] = TW'(q_tid[idx]);
            end else begin
                head_valid[i] = 1'b0; head_done[i] = 1'b0; head_nonspec[i] = 1'b0;
                head_seq[i*SW +: SW] = '0; head_tid[i*TW +: TW] = '0;
            end
        end
        a_tid    = int'($urandom % NT);
        a_v      = ($urandom % 100 < p_alloc) && (occ[a_tid] < PD);
        ns_alloc = ($urandom % 100 < p_ns);
        alloc_valid    = a_v;
        alloc_tid      = TW'(a_tid);
        trap_req       = $urandom % 2;
        stores_pending = $urandom % 2;
        #1;
        // expected retirement (R1, R2, R3)
        m = 0; going = 1;
        for (int i = 0; i < W; i++) begin
            int idx = win_idx(i);
            if (going && i < qn && q_done[idx] && !(i > 0 && q_ns[idx])) m |= (1 << i);
            else going = 0;
        end
        cnt = $countones(m);
        chk("R1/R2/R3 retire_mask", retire_mask, m);
        chk("R1 retire_cnt", retire_cnt, cnt);
        // next-cycle expectations
        if (qn > 0 && q_ns[qh] && !q_done[qh]) begin
            e_stall++;
            e_rel_v = !q_rel[qh];
            if (!q_rel[qh]) begin
                e_rel_seq = q_seq[qh];
                q_rel[qh] = 1;
            end
        end else begin
            e_rel_v = 0;
        end
        upd = 0;
        for (int t = 0; t < NT; t++) begin
            net = (a_v && a_tid == t) ? 1 : 0;
            for (int i = 0; i < cnt; i++) if (q_tid[win_idx(i)] == t) net--;
            if (net != 0) upd = 1;
            occ[t] += net;
            e_free[t] = PD - occ[t];
        end
        e_free_upd = upd;
        e_trap = trap_req && !stores_pending;
        e_hist[cnt]++;
        // the buffer advances at the edge
        qh = (qh + cnt) % QD;
        qn -= cnt;
        if (a_v) begin
            int idx = (qh + qn) % QD;
            q_seq[idx] = next_seq & 16'hFFFF; next_seq++;
            q_tid[idx] = a_tid; q_ns[idx] = ns_alloc;
            q_done[idx] = 0; q_rel[idx] = 0;
            qn++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int c = 0; c < n; c++) step();
    endtask

    initial begin
        void'($urandom(32'd7341));
        for (int t = 0; t < NT; t++) begin occ[t] = 0; e_free[t] = PD; end
        for (int k = 0; k <= W; k++) e_hist[k] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: first step checks the reset state
        // D1: six plain entries, then partial completion (R2), then a run (R1)
        p_alloc = 100; p_ns = 0; p_done = 0;
        run(6);
        p_alloc = 0;
        force_done(1); force_done(2);
        run(1);
        force_done(0);
        run(1);
        // D2: non-speculative entry behind older work, all forced complete (R3)
        p_alloc = 100; p_ns = 100;
        run(1);
        p_alloc = 0; p_ns = 0;
        for (int i = 0; i < W && i < qn; i++) force_done(i);
        run(1);
        run(1);
        // D3: waiting non-speculative head: one release, stalls (R4, R5, R6)
        p_alloc = 100; p_ns = 100;
        run(1);
        p_alloc = 0; p_ns = 0;
        run(12);
        p_done = 100;
        run(3);
        // random mix
        p_alloc = 60; p_ns = 15; p_done = 30;
        run(3000);
        // fill partitions (R7, R8)
        p_alloc = 100; p_ns = 5; p_done = 3;
        run(300);
        p_alloc = 30; p_ns = 25; p_done = 70;
        run(1000);
        check_regs();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1ms;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule